// File: doc/BRIEF.md
# Periodic Conversion Trigger Sequencer

This block produces the conversion strobes for a data converter. One start event, taken from either a hardware trigger line or a software strobe, opens a sequence. The block issues a trigger for that event, then issues its own internal triggers at a fixed spacing. It stops after a programmed number of them, or it runs without limit when that number is zero. A one-cycle conversion-done pulse from the converter tells the sequencer when each conversion has finished. The sequencer uses this to close a sequence cleanly and to raise a sticky completion flag.

Software can end a sequence in two ways. Dropping the enable bit stops it gracefully: no further triggers are issued, and the flag rises once the conversion in flight has completed. Pulsing the flush input abandons the sequence at once and returns the block to idle. The interval and count values are captured when the sequence starts, so they may be rewritten while it runs.

Top module: `periodic_trig_seq`

## Requirements
- R1: With `src_sel`=0 the start event is `hw_trig`, and with `src_sel`=1 it is `sw_trig`. A pulse on the unselected input has no effect. An accepted start drives `trig_out` high in the cycle after the start pulse.
- R2: Successive triggers of a sequence are exactly `period`+1 cycles apart, using the `period` value captured at the start.
- R3: For a nonzero `count`, exactly `count` internal triggers follow the start trigger, giving `count`+1 pulses on `trig_out` in total.
- R4: With `count`=0, internal triggers continue for as long as `seq_en` stays high, and `done_flag` stays low.
- R5: After the final trigger of a counted sequence, `done_flag` rises in the cycle after the next `conv_done` pulse.
- R6: When `seq_en` is low, no trigger is issued. If a running sequence is disabled while a conversion is in flight, `done_flag` rises in the cycle after that conversion's `conv_done`. If no conversion is in flight, it rises in the cycle after `seq_en` is sampled low.
- R7: `done_flag` holds once set until `done_clr` is pulsed. It reads low in the cycle after the pulse.
- R8: A `flush` pulse ends any sequence. The cycle after it shows `trig_out` and `done_flag` low, and no further triggers follow until a new start.
- R9: Start pulses on either source that arrive while a sequence is running are ignored. The trigger count and spacing of that sequence are unchanged.
- R10: A start pulse while `seq_en` is low is ignored.
- R11: After reset, `trig_out` and `done_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | Periodic sequencing enable |
| src_sel | input | 1 | Start source: 0 hardware line, 1 software strobe |
| hw_trig | input | 1 | Hardware start pulse |
| sw_trig | input | 1 | Software start strobe |
| period | input | PER_W | Interval between triggers, minus one |
| count | input | CNT_W | Number of internal triggers, 0 = unlimited |
| conv_done | input | 1 | One-cycle pulse when a conversion finishes |
| flush | input | 1 | Abort pulse (FIFO or software reset) |
| done_clr | input | 1 | Write-one-to-clear of the completion flag |
| trig_out | output | 1 | Registered one-cycle trigger pulse |
| done_flag | output | 1 | Sticky sequence-complete flag |

## Verification
Every result is one register stage away from the input that causes it. The start trigger appears one cycle after the start pulse. Internal triggers come `period`+1 cycles after the previous trigger. The flag appears one cycle after the closing `conv_done` or after the disabling edge, and a clear or a flush takes effect one cycle later. The bench keeps a cycle number that increments on every rising edge and samples the outputs on falling edges. It stamps each trigger and the first high cycle of the flag, then compares those stamps with the cycle offsets above. The bench's converter model returns `conv_done` two cycles after each trigger, so the flag of a counted sequence is due three cycles after its last trigger.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/start_select.sv
module start_select (
  input  logic src_sel,
  input  logic hw_trig,
  input  logic sw_trig,
  output logic start
);
  always_comb start = src_sel ? sw_trig : hw_trig;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PER_W-1:0] period_in,
  input  logic             restart,
  output logic             hit,
  output logic [PER_W-1:0] per_q
);
  logic [PER_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      tmr   <= '0;
    end else begin
      if (load) per_q <= period_in;
      if (restart) tmr <= '0;
      else if (!hit) tmr <= tmr + 1'b1;
    end
  end

  always_comb hit = (tmr == per_q);
endmodule

// File: rtl/trig_budget.sv
module trig_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count_in,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] rem;
  logic             unlimited;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem       <= '0;
      unlimited <= 1'b0;
    end else if (load) begin
      rem       <= count_in;
      unlimited <= (count_in == '0);
    end else if (dec && !unlimited) begin
      rem <= rem - 1'b1;
    end
  end

  always_comb last = !unlimited && (rem == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/periodic_trig_seq.sv
module periodic_trig_seq
  import pts_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seq_en,
  input  logic             src_sel,
  input  logic             hw_trig,
  input  logic             sw_trig,
  input  logic [PER_W-1:0] period,
  input  logic [CNT_W-1:0] count,
  input  logic             conv_done,
  input  logic             flush,
  input  logic             done_clr,
  output logic             trig_out,
  output logic             done_flag
);
  seq_state_e       state, state_nx;
  logic             start, hit, last, inflight;
  logic             start_ok, fire_int, issue, stop_run, busy_now, set_evt;
  logic [PER_W-1:0] per_q;

  start_select u_sel (
    .src_sel (src_sel),
    .hw_trig (hw_trig),
    .sw_trig (sw_trig),
    .start   (start)
  );

  interval_timer #(.PER_W(PER_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .load      (start_ok),
    .period_in (period),
    .restart   (issue),
    .hit       (hit),
    .per_q     (per_q)
  );

  trig_budget #(.CNT_W(CNT_W)) u_bud (
    .clk      (clk),
    .rst      (rst),
    .load     (start_ok),
    .count_in (count),
    .dec      (fire_int),
    .last     (last)
  );

  always_comb begin
    start_ok = (state == ST_IDLE) && seq_en && start && !flush;
    fire_int = (state == ST_RUN) && seq_en && hit && !flush;
    issue    = start_ok || fire_int;
    stop_run = (state == ST_RUN) && !seq_en;
    busy_now = inflight && !conv_done;
    set_evt  = !flush && ((stop_run && !busy_now) ||
                          ((state == ST_DRAIN) && conv_done));
    state_nx = state;
    if (flush) state_nx = ST_IDLE;
    else begin
      case (state)
        ST_IDLE:  if (start_ok) state_nx = ST_RUN;
        ST_RUN:   if (stop_run) state_nx = busy_now ? ST_DRAIN : ST_IDLE;
                  else if (fire_int && last) state_nx = ST_DRAIN;
        ST_DRAIN: if (conv_done) state_nx = ST_IDLE;
        default:  state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      inflight  <= 1'b0;
      trig_out  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      state    <= state_nx;
      trig_out <= issue;
      if (flush) inflight <= 1'b0;
      else if (issue) inflight <= 1'b1;
      else if (conv_done) inflight <= 1'b0;
      if (flush) done_flag <= 1'b0;
      else if (set_evt) done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/periodic_trig_seq_chk.sv
module periodic_trig_seq_chk #(
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             seq_en,
  input logic             conv_done,
  input logic             flush,
  input logic             done_clr,
  input logic             trig_out,
  input logic             done_flag,
  input logic [PER_W-1:0] per_q
);
  p_disable_no_trig_r6: assert property (@(posedge clk) disable iff (rst)
    !seq_en |=> !trig_out);

  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!trig_out && !done_flag));

  p_flag_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> ($past(conv_done) || !$past(seq_en)));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !done_clr && !flush) |=> done_flag);

  p_trig_single_r2: assert property (@(posedge clk) disable iff (rst)
    (trig_out && (per_q != '0)) |=> !trig_out);
endmodule

bind periodic_trig_seq periodic_trig_seq_chk #(.PER_W(PER_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .seq_en    (seq_en),
  .conv_done (conv_done),
  .flush     (flush),
  .done_clr  (done_clr),
  .trig_out  (trig_out),
  .done_flag (done_flag),
  .per_q     (per_q)
);

// File: tb/periodic_trig_seq_tb.sv
module periodic_trig_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seq_en = 1'b0, src_sel = 1'b0, hw_trig = 1'b0, sw_trig = 1'b0;
  logic [15:0] period = '0, count = '0;
  logic conv_done = 1'b0, flush = 1'b0, done_clr = 1'b0;
  logic trig_out, done_flag;

  periodic_trig_seq u_dut (
    .clk(clk), .rst(rst), .seq_en(seq_en), .src_sel(src_sel),
    .hw_trig(hw_trig), .sw_trig(sw_trig), .period(period), .count(count),
    .conv_done(conv_done), .flush(flush), .done_clr(done_clr),
    .trig_out(trig_out), .done_flag(done_flag)
  );

  always #4 clk = ~clk;

  // {src[40], period[39:24], count[23:8], expected triggers[7:0]}
  localparam logic [40:0] VEC [5] = '{
    {1'b0, 16'd2, 16'd1, 8'd2},
    {1'b1, 16'd3, 16'd3, 8'd4},
    {1'b0, 16'd5, 16'd2, 8'd3},
    {1'b1, 16'd2, 16'd4, 8'd5},
    {1'b0, 16'd7, 16'd1, 8'd2}
  };

  int cyc = 0, checks = 0, fails = 0;
  int ntr, first_c, last_c, flag_c, gap_err, exp_gap;
  logic [2:0] pipe = '0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (trig_out) begin
      if (ntr > 0 && (cyc - last_c) != exp_gap) gap_err++;
      if (ntr == 0) first_c = cyc;
      last_c = cyc;
      ntr++;
    end
    if (done_flag && flag_c < 0) flag_c = cyc;
    pipe = {pipe[1:0], trig_out};
    conv_done = pipe[2];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    ntr = 0; first_c = -1; last_c = -1; flag_c = -1; gap_err = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic pulse_start(input bit src, output int s);
    @(negedge clk); #1;
    clr_stats();
    s = cyc;
    if (src) sw_trig = 1'b1; else hw_trig = 1'b1;
    @(negedge clk); #1;
    hw_trig = 1'b0; sw_trig = 1'b0;
  endtask

  task automatic wait_flag();
    for (int k = 0; k < 400 && flag_c < 0; k++) @(negedge clk);
    #1;
  endtask

  task automatic clear_flag();
    @(negedge clk); #1; done_clr = 1'b1;
    @(negedge clk); #1; done_clr = 1'b0;
  endtask

  task automatic wait_trig(output int l);
    l = -1;
    for (int k = 0; k < 100 && l < 0; k++) begin
      @(negedge clk); #1;
      if (trig_out) l = cyc;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int s, l, n0;
    clr_stats();
    exp_gap = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!trig_out && !done_flag, "R11 reset", {trig_out, done_flag}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // table walk: R1 R2 R3 R5 R7
    for (int i = 0; i < 5; i++) begin
      src_sel = VEC[i][40]; period = VEC[i][39:24]; count = VEC[i][23:8];
      exp_gap = int'(VEC[i][39:24]) + 1;
      seq_en = 1'b1;
      pulse_start(VEC[i][40], s);
      wait_flag();
      check(first_c == s + 1, "R1 start latency", first_c - s, 1);
      check(ntr == int'(VEC[i][7:0]), "R3 trigger total", ntr, int'(VEC[i][7:0]));
      check(gap_err == 0, "R2 spacing", gap_err, 0);
      check(flag_c == last_c + 3, "R5 flag timing", flag_c - last_c, 3);
      repeat (3) @(negedge clk); #1;
      check(done_flag, "R7 sticky", done_flag, 1);
      clear_flag();
      check(!done_flag, "R7 clear", done_flag, 0);
    end

    // R4 unlimited, then R6 disable with a conversion in flight
    src_sel = 1'b1; period = 16'd3; count = 16'd0; exp_gap = 4;
    pulse_start(1'b1, s);
    repeat (40) @(negedge clk); #1;
    check(ntr >= 9 && flag_c < 0, "R4 unlimited", ntr, 9);
    check(gap_err == 0, "R4 spacing", gap_err, 0);
    wait_trig(l);
    seq_en = 1'b0;
    n0 = ntr;
    wait_flag();
    check(flag_c == l + 3, "R6 drain flag", flag_c - l, 3);
    repeat (10) @(negedge clk); #1;
    check(ntr == n0, "R6 no trig after disable", ntr, n0);
    clear_flag();

    // R6 disable with nothing in flight
    period = 16'd6; seq_en = 1'b1; exp_gap = 7;
    pulse_start(1'b1, s);
    wait_trig(l);
    repeat (3) @(negedge clk); #1;
    seq_en = 1'b0;
    wait_flag();
    check(flag_c == l + 4, "R6 idle disable flag", flag_c - l, 4);
    clear_flag();

    // R8 flush mid-sequence
    seq_en = 1'b1; period = 16'd3; count = 16'd5; exp_gap = 4;
    pulse_start(1'b1, s);
    wait_trig(l);
    wait_trig(l);
    flush = 1'b1;
    @(negedge clk); #1;
    flush = 1'b0;
    check(!trig_out && !done_flag, "R8 flush outputs", {trig_out, done_flag}, 0);
    n0 = ntr;
    repeat (25) @(negedge clk); #1;
    check(ntr == n0 && !done_flag, "R8 flush ends sequence", ntr, n0);

    // R9 starts during a running sequence are ignored
    src_sel = 1'b0; period = 16'd4; count = 16'd3; exp_gap = 5;
    pulse_start(1'b0, s);
    repeat (2) @(negedge clk); #1;
    hw_trig = 1'b1; sw_trig = 1'b1;
    @(negedge clk); #1;
    hw_trig = 1'b0; sw_trig = 1'b0;
    wait_flag();
    check(ntr == 4 && gap_err == 0, "R9 ignored restarts", ntr, 4);
    clear_flag();

    // R10 start while disabled
    seq_en = 1'b0;
    pulse_start(1'b0, s);
    repeat (10) @(negedge clk); #1;
    check(ntr == 0, "R10 disabled start", ntr, 0);

    // R1 unselected source ignored
    seq_en = 1'b1; src_sel = 1'b1;
    pulse_start(1'b0, s);
    repeat (10) @(negedge clk); #1;
    check(ntr == 0, "R1 unselected source", ntr, 0);

    finish_run();
  end
endmodule